// File: doc/BRIEF.md
# Display Mode Timing Parameter Calculator

This block turns a display mode into the numbers that a video timing engine needs. For each axis the mode is given as four positions: the end of the active area, the start of sync, the end of sync and the total line or frame length. From these the block derives the front porch, sync width and back porch. It also derives two sync polarities, fixed border and underflow colours, and a prefetch window with the matching fetch start counter value.

Before any conversion the block checks that the mode is consistent. It then adjusts the result for the interface it drives. A serial-panel link gets active-high syncs. A DisplayPort-style link gets its front porch folded into the back porch. A wide data path on that link halves the horizontal figures, and a split-panel arrangement halves the horizontal input positions.

A caller latches a mode with a one-cycle `start`. After a fixed number of cycles the block pulses `done`, and its outputs then stay constant until the next accepted start. A single multiplier is shared for the fetch counter product.

Top module: `mode_timing_calc`

## Requirements
- R1: A mode is rejected when, on either axis, total < sync end, sync start < active, or sync end < sync start. A rejected mode raises `mode_bad` with `done` and drives every parameter output to zero: porches, widths, active sizes, polarities, both colours, prefetch lines, fetch enable and fetch start. Equal positions are accepted.
- R2: For each axis, back porch = total − sync end, front porch = sync start − active, and sync width = sync end − sync start.
- R3: Interface code 1 (serial panel) forces both polarity outputs to 0 (active high). Any other code takes `hsync_low` from flag bit 0 and `vsync_low` from flag bit 1.
- R4: With interface code 2 (DisplayPort style), on both axes the front porch is added to the back porch and the front porch output becomes zero.
- R5: With interface code 2 and `wide_bus` set, the horizontal active width, back porch, front porch and sync width are each shifted right by one after the R4 step.
- R6: With `split_on` set, the horizontal active, sync start, sync end and total inputs are shifted right by one before validation and conversion.
- R7: For an accepted mode the border colour is 0 and the underflow colour is all ones.
- R8: Let S = vertical back porch + vertical sync width. Prefetch lines are 0 if S ≥ worst-case count. If the vertical front porch is below worst-case − S, they equal the vertical front porch. Otherwise they equal worst-case − S.
- R9: With nonzero prefetch lines, `fetch_en` is 1 and `fetch_start` = (vtotal − lines) × htotal + 1, where each total is active + both porches + sync width after adjustment. Otherwise `fetch_en` and `fetch_start` are 0.
- R10: A start sampled while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, in the fourth cycle after the start edge.
- R11: Outputs change only in the cycle `done` rises, and they hold their values after it. A start sampled while `busy` is high is ignored.
- R12: After reset, `done`, `busy`, `mode_bad` and every parameter output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the mode and begin a calculation |
| h_act_in | input | W | Horizontal active end position |
| h_ss_in | input | W | Horizontal sync start position |
| h_se_in | input | W | Horizontal sync end position |
| h_tot_in | input | W | Horizontal total |
| v_act_in | input | W | Vertical active end position |
| v_ss_in | input | W | Vertical sync start position |
| v_se_in | input | W | Vertical sync end position |
| v_tot_in | input | W | Vertical total |
| neg_flags | input | 2 | Bit 0 negative hsync, bit 1 negative vsync |
| if_kind | input | 2 | 0 plain, 1 serial panel, 2 DisplayPort style, 3 plain |
| wide_bus | input | 1 | Wide data path enable |
| split_on | input | 1 | Split-panel (not solo) operation |
| worst_lines | input | W | Worst-case prefetch line count |
| h_active | output | W | Horizontal active width |
| h_front | output | W | Horizontal front porch |
| h_back | output | W | Horizontal back porch |
| h_sync | output | W | Horizontal sync width |
| v_active | output | W | Vertical active height |
| v_front | output | W | Vertical front porch |
| v_back | output | W | Vertical back porch |
| v_sync | output | W | Vertical sync width |
| hsync_low | output | 1 | Horizontal sync active low |
| vsync_low | output | 1 | Vertical sync active low |
| border_color | output | CW | Border colour |
| underflow_color | output | CW | Underflow colour |
| prefetch_lines | output | W | Lines of prefetch taken from the front porch |
| fetch_en | output | 1 | Prefetch enable |
| fetch_start | output | 2*(W+2) | Fetch start counter value |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Calculation in progress |
| mode_bad | output | 1 | Last mode failed validation |

## Verification
The bench targets three groups of corner cases.

The first is the validation boundary: positions that are exactly equal must be accepted, while each single inverted pair on either axis must be rejected. A wrong comparison direction would either reject a legal zero-porch mode or pass nonsense porches through as wrapped values.

The second is the three prefetch branches, including the case where the front porch is too short and must clamp the result. Getting the clamp wrong would put the fetch start inside the active lines, or outside the frame altogether.

The third is the combination of split and wide-bus halving on odd values, where halving in the wrong order or on the wrong fields shifts the horizontal total. The bench also retriggers `start` while the block is busy, which would corrupt a result if that start were not ignored.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    IF_PLAIN  = 2'd0,
    IF_SERIAL = 2'd1,
    IF_DPORT  = 2'd2,
    IF_SPARE  = 2'd3
  } if_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_AXIS = 2'd1,
    S_MUL  = 2'd2,
    S_OUT  = 2'd3
  } calc_state_e;
endpackage

// File: rtl/mtc_axis.sv
module mtc_axis #(
  parameter int W     = 16,
  parameter int HORIZ = 1
) (
  input  logic [W-1:0] act,
  input  logic [W-1:0] ss,
  input  logic [W-1:0] se,
  input  logic [W-1:0] tot,
  input  logic         halve,
  input  logic         dport,
  input  logic         wide,
  output logic         ok,
  output logic [W-1:0] act_o,
  output logic [W-1:0] fp,
  output logic [W-1:0] bp,
  output logic [W-1:0] sw,
  output logic [W+1:0] total
);
  localparam logic IS_H = (HORIZ != 0);

  function automatic logic [W-1:0] half_if(input logic [W-1:0] v, input logic en);
    return en ? (v >> 1) : v;
  endfunction

  function automatic logic [W+1:0] add4(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c, input logic [W-1:0] d);
    return {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d};
  endfunction

  logic         split_en, narrow_en;
  logic [W-1:0] a, s, e, t, fp0, bp0, sw0, fp1, bp1;

  assign split_en  = halve & IS_H;
  assign narrow_en = dport & wide & IS_H;

  always_comb begin
    a   = half_if(act, split_en);
    s   = half_if(ss, split_en);
    e   = half_if(se, split_en);
    t   = half_if(tot, split_en);
    ok  = (t >= e) && (s >= a) && (e >= s);
    fp0 = s - a;
    sw0 = e - s;
    bp0 = t - e;
    fp1 = dport ? '0 : fp0;
    bp1 = dport ? (bp0 + fp0) : bp0;
    act_o = half_if(a, narrow_en);
    fp    = half_if(fp1, narrow_en);
    bp    = half_if(bp1, narrow_en);
    sw    = half_if(sw0, narrow_en);
    total = add4(act_o, fp, bp, sw);
  end
endmodule

// File: rtl/mtc_prefetch.sv
module mtc_prefetch #(
  parameter int W = 16
) (
  input  logic [W-1:0] vfp,
  input  logic [W-1:0] vbp,
  input  logic [W-1:0] vsw,
  input  logic [W-1:0] worst,
  output logic [W-1:0] lines
);
  function automatic logic [W-1:0] pick_lines(input logic [W-1:0] f, input logic [W-1:0] b,
                                              input logic [W-1:0] s, input logic [W-1:0] wc);
    logic [W:0]   sof;
    logic [W-1:0] need;
    sof  = {1'b0, b} + {1'b0, s};
    need = wc - sof[W-1:0];
    if (sof >= {1'b0, wc}) return '0;
    else if (f < need)     return f;
    else                   return need;
  endfunction

  assign lines = pick_lines(vfp, vbp, vsw, worst);
endmodule

// File: rtl/mtc_mul.sv
module mtc_mul #(
  parameter int AW = 18,
  parameter int BW = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);
  always_ff @(posedge clk) begin
    if (!rst_n)  p <= '0;
    else if (en) p <= {{BW{1'b0}}, a} * {{AW{1'b0}}, b};
  end
endmodule

// File: rtl/mode_timing_calc.sv
module mode_timing_calc #(
  parameter  int W  = 16,
  parameter  int CW = 8,
  localparam int TW = W + 2,
  localparam int FW = 2 * TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  h_act_in,
  input  logic [W-1:0]  h_ss_in,
  input  logic [W-1:0]  h_se_in,
  input  logic [W-1:0]  h_tot_in,
  input  logic [W-1:0]  v_act_in,
  input  logic [W-1:0]  v_ss_in,
  input  logic [W-1:0]  v_se_in,
  input  logic [W-1:0]  v_tot_in,
  input  logic [1:0]    neg_flags,
  input  logic [1:0]    if_kind,
  input  logic          wide_bus,
  input  logic          split_on,
  input  logic [W-1:0]  worst_lines,
  output logic [W-1:0]  h_active,
  output logic [W-1:0]  h_front,
  output logic [W-1:0]  h_back,
  output logic [W-1:0]  h_sync,
  output logic [W-1:0]  v_active,
  output logic [W-1:0]  v_front,
  output logic [W-1:0]  v_back,
  output logic [W-1:0]  v_sync,
  output logic          hsync_low,
  output logic          vsync_low,
  output logic [CW-1:0] border_color,
  output logic [CW-1:0] underflow_color,
  output logic [W-1:0]  prefetch_lines,
  output logic          fetch_en,
  output logic [FW-1:0] fetch_start,
  output logic          done,
  output logic          busy,
  output logic          mode_bad
);
  import mtc_pkg::*;

  calc_state_e st;
  logic        launch;

  // latched mode
  logic [W-1:0] l_ha, l_hs, l_he, l_ht, l_va, l_vs, l_ve, l_vt, l_wc;
  logic [1:0]   l_flags;
  if_kind_e     l_kind;
  logic         l_wide, l_split;

  // combinational axis results
  logic         h_ok, v_ok;
  logic [W-1:0] ha_c, hf_c, hb_c, hs_c, va_c, vf_c, vb_c, vs_c, pl_c;
  logic [TW-1:0] ht_c, vt_c;

  // registered intermediate results
  logic          r_ok, r_hp, r_vp;
  logic [W-1:0]  r_ha, r_hf, r_hb, r_hs, r_va, r_vf, r_vb, r_vs, r_pl;
  logic [TW-1:0] r_ht, r_vt;
  logic [FW-1:0] prod;

  assign busy   = (st != S_IDLE);
  assign launch = start && !busy;

  mtc_axis #(.W(W), .HORIZ(1)) u_h (
    .act(l_ha), .ss(l_hs), .se(l_he), .tot(l_ht),
    .halve(l_split), .dport(l_kind == IF_DPORT), .wide(l_wide),
    .ok(h_ok), .act_o(ha_c), .fp(hf_c), .bp(hb_c), .sw(hs_c), .total(ht_c));

  mtc_axis #(.W(W), .HORIZ(0)) u_v (
    .act(l_va), .ss(l_vs), .se(l_ve), .tot(l_vt),
    .halve(l_split), .dport(l_kind == IF_DPORT), .wide(l_wide),
    .ok(v_ok), .act_o(va_c), .fp(vf_c), .bp(vb_c), .sw(vs_c), .total(vt_c));

  mtc_prefetch #(.W(W)) u_pf (
    .vfp(vf_c), .vbp(vb_c), .vsw(vs_c), .worst(l_wc), .lines(pl_c));

  mtc_mul #(.AW(TW), .BW(TW)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(st == S_MUL),
    .a(r_vt - {2'b00, r_pl}), .b(r_ht), .p(prod));

  // sequencing and input latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      l_ha    <= '0; l_hs <= '0; l_he <= '0; l_ht <= '0;
      l_va    <= '0; l_vs <= '0; l_ve <= '0; l_vt <= '0;
      l_wc    <= '0; l_flags <= '0; l_kind <= IF_PLAIN;
      l_wide  <= 1'b0; l_split <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          st      <= S_AXIS;
          l_ha    <= h_act_in; l_hs <= h_ss_in; l_he <= h_se_in; l_ht <= h_tot_in;
          l_va    <= v_act_in; l_vs <= v_ss_in; l_ve <= v_se_in; l_vt <= v_tot_in;
          l_wc    <= worst_lines;
          l_flags <= neg_flags;
          l_kind  <= if_kind_e'(if_kind);
          l_wide  <= wide_bus;
          l_split <= split_on;
        end
        S_AXIS:  st <= S_MUL;
        S_MUL:   st <= S_OUT;
        default: st <= S_IDLE;
      endcase
    end
  end

  // intermediate capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ok <= 1'b0; r_hp <= 1'b0; r_vp <= 1'b0;
      r_ha <= '0; r_hf <= '0; r_hb <= '0; r_hs <= '0;
      r_va <= '0; r_vf <= '0; r_vb <= '0; r_vs <= '0;
      r_pl <= '0; r_ht <= '0; r_vt <= '0;
    end else if (st == S_AXIS) begin
      r_ok <= h_ok && v_ok;
      r_hp <= (l_kind == IF_SERIAL) ? 1'b0 : l_flags[0];
      r_vp <= (l_kind == IF_SERIAL) ? 1'b0 : l_flags[1];
      r_ha <= ha_c; r_hf <= hf_c; r_hb <= hb_c; r_hs <= hs_c;
      r_va <= va_c; r_vf <= vf_c; r_vb <= vb_c; r_vs <= vs_c;
      r_pl <= pl_c; r_ht <= ht_c; r_vt <= vt_c;
    end
  end

  // result registers, updated only with done
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; mode_bad <= 1'b0;
      h_active <= '0; h_front <= '0; h_back <= '0; h_sync <= '0;
      v_active <= '0; v_front <= '0; v_back <= '0; v_sync <= '0;
      hsync_low <= 1'b0; vsync_low <= 1'b0;
      border_color <= '0; underflow_color <= '0;
      prefetch_lines <= '0; fetch_en <= 1'b0; fetch_start <= '0;
    end else begin
      done <= (st == S_OUT);
      if (st == S_OUT) begin
        mode_bad        <= !r_ok;
        border_color    <= '0;
        h_active        <= r_ok ? r_ha : '0;
        h_front         <= r_ok ? r_hf : '0;
        h_back          <= r_ok ? r_hb : '0;
        h_sync          <= r_ok ? r_hs : '0;
        v_active        <= r_ok ? r_va : '0;
        v_front         <= r_ok ? r_vf : '0;
        v_back          <= r_ok ? r_vb : '0;
        v_sync          <= r_ok ? r_vs : '0;
        hsync_low       <= r_ok && r_hp;
        vsync_low       <= r_ok && r_vp;
        underflow_color <= r_ok ? '1 : '0;
        prefetch_lines  <= r_ok ? r_pl : '0;
        fetch_en        <= r_ok && (r_pl != '0);
        fetch_start     <= (r_ok && (r_pl != '0)) ? (prod + FW'(1)) : '0;
      end
    end
  end
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int W  = 16,
  parameter int FW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          launch,
  input logic          busy,
  input logic          done,
  input logic          mode_bad,
  input logic          fetch_en,
  input logic [FW-1:0] fetch_start,
  input logic [W-1:0]  prefetch_lines,
  input logic [W-1:0]  v_front,
  input logic [W-1:0]  h_back
);
  assert_launch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fetch_start) && $stable(mode_bad) && $stable(h_back)));

  assert_bad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> (!fetch_en && fetch_start == '0 && h_back == '0 && prefetch_lines == '0));

  assert_lines_in_porch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_lines <= v_front);

  assert_fetch_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> (fetch_start != '0 && prefetch_lines != '0));
endmodule

bind mode_timing_calc mtc_checker #(.W(W), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .done(done),
  .mode_bad(mode_bad), .fetch_en(fetch_en), .fetch_start(fetch_start),
  .prefetch_lines(prefetch_lines), .v_front(v_front), .h_back(h_back));

// File: tb/tb_mode_timing_calc.sv
`timescale 1ns/1ps
module tb_mode_timing_calc;
  localparam int W  = 16;
  localparam int CW = 8;
  localparam int FW = 2 * (W + 2);
  localparam int NV = 12;

  // {hA,hS,hE,hT,vA,vS,vE,vT,worst,flags[1:0],kind[1:0],wide,split}
  localparam logic [149:0] TAB [NV] = '{
    {16'd100, 16'd110, 16'd120, 16'd150, 16'd50, 16'd53, 16'd55, 16'd60, 16'd10, 2'd0, 2'd0, 1'b0, 1'b0},
    {16'd100, 16'd110, 16'd120, 16'd150, 16'd50, 16'd53, 16'd55, 16'd60, 16'd10, 2'd3, 2'd1, 1'b0, 1'b0},
    {16'd100, 16'd110, 16'd120, 16'd150, 16'd50, 16'd53, 16'd55, 16'd60, 16'd5,  2'd3, 2'd0, 1'b0, 1'b0},
    {16'd640, 16'd656, 16'd752, 16'd800, 16'd480, 16'd490, 16'd492, 16'd525, 16'd60, 2'd1, 2'd2, 1'b0, 1'b0},
    {16'd1920, 16'd2008, 16'd2052, 16'd2200, 16'd1080, 16'd1084, 16'd1089, 16'd1125, 16'd30, 2'd2, 2'd2, 1'b1, 1'b0},
    {16'd1000, 16'd1020, 16'd1040, 16'd1100, 16'd600, 16'd603, 16'd609, 16'd625, 16'd30, 2'd0, 2'd0, 1'b0, 1'b1},
    {16'd100, 16'd90,  16'd120, 16'd150, 16'd50, 16'd53, 16'd55, 16'd60, 16'd10, 2'd1, 2'd0, 1'b0, 1'b0},
    {16'd100, 16'd110, 16'd120, 16'd150, 16'd50, 16'd53, 16'd55, 16'd54, 16'd10, 2'd0, 2'd0, 1'b0, 1'b0},
    {16'd100, 16'd110, 16'd120, 16'd150, 16'd50, 16'd51, 16'd53, 16'd58, 16'd20, 2'd0, 2'd0, 1'b0, 1'b0},
    {16'd101, 16'd113, 16'd127, 16'd151, 16'd50, 16'd53, 16'd55, 16'd60, 16'd12, 2'd2, 2'd2, 1'b1, 1'b1},
    {16'd100, 16'd110, 16'd105, 16'd150, 16'd50, 16'd53, 16'd55, 16'd60, 16'd10, 2'd0, 2'd0, 1'b0, 1'b0},
    {16'd64,  16'd64,  16'd64,  16'd64,  16'd10, 16'd10, 16'd10, 16'd10, 16'd0,  2'd0, 2'd0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  h_act_in = '0, h_ss_in = '0, h_se_in = '0, h_tot_in = '0;
  logic [W-1:0]  v_act_in = '0, v_ss_in = '0, v_se_in = '0, v_tot_in = '0;
  logic [1:0]    neg_flags = '0, if_kind = '0;
  logic          wide_bus = 1'b0, split_on = 1'b0;
  logic [W-1:0]  worst_lines = '0;
  logic [W-1:0]  h_active, h_front, h_back, h_sync, v_active, v_front, v_back, v_sync;
  logic          hsync_low, vsync_low, fetch_en, done, busy, mode_bad;
  logic [CW-1:0] border_color, underflow_color;
  logic [W-1:0]  prefetch_lines;
  logic [FW-1:0] fetch_start;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  // expected values
  longint e_ha, e_hf, e_hb, e_hs, e_va, e_vf, e_vb, e_vs, e_hp, e_vp, e_uf, e_pl, e_fe, e_fs, e_bad;

  always #5 clk = ~clk;

  mode_timing_calc #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .h_act_in(h_act_in), .h_ss_in(h_ss_in), .h_se_in(h_se_in), .h_tot_in(h_tot_in),
    .v_act_in(v_act_in), .v_ss_in(v_ss_in), .v_se_in(v_se_in), .v_tot_in(v_tot_in),
    .neg_flags(neg_flags), .if_kind(if_kind), .wide_bus(wide_bus), .split_on(split_on),
    .worst_lines(worst_lines),
    .h_active(h_active), .h_front(h_front), .h_back(h_back), .h_sync(h_sync),
    .v_active(v_active), .v_front(v_front), .v_back(v_back), .v_sync(v_sync),
    .hsync_low(hsync_low), .vsync_low(vsync_low),
    .border_color(border_color), .underflow_color(underflow_color),
    .prefetch_lines(prefetch_lines), .fetch_en(fetch_en), .fetch_start(fetch_start),
    .done(done), .busy(busy), .mode_bad(mode_bad));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [149:0] v);
    h_act_in = v[149:134]; h_ss_in = v[133:118]; h_se_in = v[117:102]; h_tot_in = v[101:86];
    v_act_in = v[85:70];   v_ss_in = v[69:54];   v_se_in = v[53:38];   v_tot_in = v[37:22];
    worst_lines = v[21:6]; neg_flags = v[5:4];   if_kind = v[3:2];
    wide_bus = v[1];       split_on = v[0];
  endtask

  // reference model, written from the requirements with plain integers
  task automatic model(input logic [149:0] v);
    longint ha, hs, he, ht, va, vs, ve, vt, wc, kind, sof, need, htot, vtot;
    ha = v[149:134]; hs = v[133:118]; he = v[117:102]; ht = v[101:86];
    va = v[85:70];   vs = v[69:54];   ve = v[53:38];   vt = v[37:22];
    wc = v[21:6];    kind = v[3:2];
    if (v[0]) begin ha = ha / 2; hs = hs / 2; he = he / 2; ht = ht / 2; end   // R6
    e_bad = (ht < he || hs < ha || he < hs || vt < ve || vs < va || ve < vs) ? 1 : 0;
    if (e_bad != 0) begin
      e_ha = 0; e_hf = 0; e_hb = 0; e_hs = 0; e_va = 0; e_vf = 0; e_vb = 0; e_vs = 0;
      e_hp = 0; e_vp = 0; e_uf = 0; e_pl = 0; e_fe = 0; e_fs = 0;
      return;
    end
    e_ha = ha; e_hf = hs - ha; e_hs = he - hs; e_hb = ht - he;
    e_va = va; e_vf = vs - va; e_vs = ve - vs; e_vb = vt - ve;
    if (kind == 2) begin                                                     // R4
      e_hb = e_hb + e_hf; e_hf = 0; e_vb = e_vb + e_vf; e_vf = 0;
      if (v[1]) begin e_ha = e_ha / 2; e_hb = e_hb / 2; e_hs = e_hs / 2; end // R5
    end
    e_hp = (kind == 1) ? 0 : longint'(v[4]);
    e_vp = (kind == 1) ? 0 : longint'(v[5]);
    e_uf = 255;
    sof  = e_vb + e_vs;
    need = wc - sof;
    if (sof >= wc)      e_pl = 0;
    else if (e_vf < need) e_pl = e_vf;
    else                e_pl = need;
    htot = e_ha + e_hf + e_hb + e_hs;
    vtot = e_va + e_vf + e_vb + e_vs;
    e_fe = (e_pl != 0) ? 1 : 0;
    e_fs = (e_pl != 0) ? ((vtot - e_pl) * htot + 1) : 0;
  endtask

  task automatic compare_all();
    chk("R1", "mode_bad", longint'(mode_bad), e_bad);
    chk("R2", "h_active", longint'(h_active), e_ha);
    chk("R2", "h_front", longint'(h_front), e_hf);
    chk("R2", "h_back", longint'(h_back), e_hb);
    chk("R2", "h_sync", longint'(h_sync), e_hs);
    chk("R4", "v_active", longint'(v_active), e_va);
    chk("R4", "v_front", longint'(v_front), e_vf);
    chk("R4", "v_back", longint'(v_back), e_vb);
    chk("R5", "v_sync", longint'(v_sync), e_vs);
    chk("R3", "hsync_low", longint'(hsync_low), e_hp);
    chk("R3", "vsync_low", longint'(vsync_low), e_vp);
    chk("R7", "border", longint'(border_color), 0);
    chk("R7", "underflow", longint'(underflow_color), e_uf);
    chk("R8", "prefetch_lines", longint'(prefetch_lines), e_pl);
    chk("R9", "fetch_en", longint'(fetch_en), e_fe);
    chk("R9", "fetch_start", longint'(fetch_start), e_fs);
  endtask

  task automatic run_vec(input logic [149:0] v);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", longint'(busy), 1);
    chk("R10", "done early", longint'(done), 0);
    repeat (3) @(negedge clk);
    chk("R10", "done at latency", longint'(done), 1);
    model(v);
    compare_all();
    @(negedge clk);
    chk("R10", "done one cycle", longint'(done), 0);
    chk("R11", "held fetch_start", longint'(fetch_start), e_fs);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "done", longint'(done), 0);
    chk("R12", "busy", longint'(busy), 0);
    chk("R12", "mode_bad", longint'(mode_bad), 0);
    chk("R12", "fetch_en", longint'(fetch_en), 0);
    chk("R12", "fetch_start", longint'(fetch_start), 0);
    chk("R12", "underflow", longint'(underflow_color), 0);
    chk("R12", "h_back", longint'(h_back), 0);

    for (int i = 0; i < NV; i++) run_vec(TAB[i]);

    // R9: hand-computed value for the first vector: (60-3)*150+1
    run_vec(TAB[0]);
    chk("R9", "literal fetch_start", longint'(fetch_start), 8551);
    chk("R8", "literal lines", longint'(prefetch_lines), 3);
    // R8: clamp case, front porch 1 shorter than need 13
    run_vec(TAB[8]);
    chk("R8", "clamped lines", longint'(prefetch_lines), 1);

    // R11: start while busy is ignored
    apply(TAB[0]);
    start = 1'b1;
    @(negedge clk);
    apply(TAB[6]);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10 && !done; k++) @(negedge clk);
    chk("R11", "busy start ignored bad", longint'(mode_bad), 0);
    chk("R11", "busy start ignored fs", longint'(fetch_start), 8551);

    // R11: outputs hold while inputs change without start
    apply(TAB[7]);
    repeat (5) @(negedge clk);
    chk("R11", "hold done", longint'(done), 0);
    chk("R11", "hold fetch_start", longint'(fetch_start), 8551);
    chk("R11", "hold h_back", longint'(h_back), 30);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule